// File: doc/BRIEF.md
# GPIB Source Handshake Engine

This block is the talker half of the three-wire IEEE 488 byte handshake. A processor or DMA engine writes one byte into the output holding register. The byte goes onto the DIO lines at once. A settling timer then runs for one of four programmable intervals. After that the engine waits until every acceptor reports ready before it raises DAV. When the acceptors signal that the byte has been taken, the engine drops DAV. Depending on the transfer mode, it then raises either a byte-out interrupt flag or a DMA request.

Two kinds of bus condition are guarded against. If nobody is listening after the settle interval, DAV is never raised and a sticky error bit is set; the byte stays parked until a listener appears. If ATN is asserted by another controller during a transfer, the engine freezes and keeps the byte. When ATN is released, it repeats the settle interval and offers the same byte again.

Bus lines are logical, active-high signals: a 1 on `nrfd` means some device is holding "not ready", and a 1 on `ndac` means some device has not yet accepted.

Top module: `gpib_src_hs`

## Requirements
- R1: After reset, `dav`, `bo_flag`, `dma_req` and `nolsn_err` are all 0.
- R2: A write (`wr_en`=1) while the engine is idle and not frozen puts `wr_data` on `dio` after that edge and clears `bo_flag` and `dma_req`. A write at any other time leaves `dio` unchanged.
- R3: With a ready bus (`nrfd`=0, `ndac`=1), `dav` rises exactly N+2 clock edges after the write edge. N = ceil(T_ns * CLK_MHZ / 1000), where `dly_sel` 0, 1, 2 and 3 select T = 350, 500, 1100 and 2000 ns. At 200 MHz this gives N = 70, 100, 220 and 400.
- R4: `dav` is raised only on an edge where `nrfd`=0 and `ndac`=1. While `nrfd`=1 the engine keeps waiting with `dav` low.
- R5: If the settle interval has ended and `nrfd`=0 and `ndac`=0 (no listener), `dav` stays low and `nolsn_err` is set. `nolsn_err` stays 1 until an `err_clr` pulse; a set condition wins over a clear. The held byte is sent once `ndac` returns to 1.
- R6: When `ndac` goes to 0 while `dav`=1, `dav` falls on the next edge. On that same edge `bo_flag` (when `dma_mode`=0) or `dma_req` (when `dma_mode`=1) is set, and it stays set until the next accepted write.
- R7: After `dav` falls, the engine accepts no new write until `ndac` has returned to 1.
- R8: While `atn`=1 and `ctrl_active`=0, `dav` is 0 after the next edge, `dio` keeps the held byte, and writes are ignored. On the first edge after ATN is released, the settle interval restarts, so `dav` rises N+2 edges after that edge.
- R9: While `ctrl_active`=1, `atn` has no effect on the handshake or its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the output byte |
| wr_data | input | DW | Byte to source |
| dly_sel | input | 2 | Settling interval select |
| dma_mode | input | 1 | 1: request the next byte by DMA request, 0: by interrupt flag |
| ctrl_active | input | 1 | Engine belongs to the controller in charge (ATN does not freeze it) |
| atn | input | 1 | ATN line, 1 = asserted |
| nrfd | input | 1 | NRFD line, 1 = some device not ready |
| ndac | input | 1 | NDAC line, 1 = some device has not accepted |
| err_clr | input | 1 | Clears the no-listener error |
| dio | output | DW | Byte driven onto the data lines |
| dav | output | 1 | DAV line drive, 1 = data valid |
| bo_flag | output | 1 | Byte-out interrupt flag |
| dma_req | output | 1 | DMA request for the next byte |
| nolsn_err | output | 1 | Sticky no-listener error |

## Verification
The inline assertions check several rules on every cycle:
- DAV only ever rises out of a ready bus with a listener present.
- The settle timer only finishes after the exact count it was loaded with.
- A freeze drops DAV and holds the data register.
- The two request outputs are mutually exclusive and each rises only on an accepted byte.
- The error bit cannot vanish without a clear.

Some behaviour only the bench scenarios can show. These are the absolute N+2 latency for each delay setting, a write being ignored during settle or before NDAC has returned, the parked byte being sent once a listener shows up, the full restart of the settle interval after ATN release, and ATN being ignored under controller ownership.

// File: rtl/gsh_pkg.sv
package gsh_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_LOAD,
    S_SETTLE,
    S_WRDY,
    S_ACPT,
    S_DONE,
    S_HOLD
  } hs_state_t;

  // cycles needed to cover a delay of ns at mhz, rounded up
  function automatic int ns2cyc(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/gsh_settle_timer.sv
module gsh_settle_timer
  import gsh_pkg::*;
#(
  parameter int CLK_MHZ = 200,
  parameter int T0_NS   = 350,
  parameter int T1_NS   = 500,
  parameter int T2_NS   = 1100,
  parameter int T3_NS   = 2000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       load_i,
  input  logic       run_i,
  input  logic [1:0] sel_i,
  output logic       done_o
);

  localparam int C0   = ns2cyc(T0_NS, CLK_MHZ);
  localparam int C1   = ns2cyc(T1_NS, CLK_MHZ);
  localparam int C2   = ns2cyc(T2_NS, CLK_MHZ);
  localparam int C3   = ns2cyc(T3_NS, CLK_MHZ);
  localparam int CMAX = max2(max2(C0, C1), max2(C2, C3));
  localparam int CW   = $clog2(CMAX + 1);

  logic [CW-1:0] len;
  logic [CW-1:0] cnt;

  always_comb begin
    case (sel_i)
      2'd0:    len = CW'(C0);
      2'd1:    len = CW'(C1);
      2'd2:    len = CW'(C2);
      default: len = CW'(C3);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (load_i)                cnt <= len - CW'(1);
    else if (run_i && cnt != '0)    cnt <= cnt - CW'(1);
  end

  assign done_o = run_i && (cnt == '0);

  // checker: independent up-count of settle cycles since load
  logic [CW-1:0] chk_up;
  logic [CW-1:0] chk_len;

  always_ff @(posedge clk) begin
    if (rst) begin
      chk_up  <= '0;
      chk_len <= '0;
    end else if (load_i) begin
      chk_up  <= '0;
      chk_len <= len;
    end else if (run_i && !done_o) begin
      chk_up  <= chk_up + CW'(1);
    end
  end

  assert_settle_len_R3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (chk_up == chk_len - CW'(1)));

endmodule

// File: rtl/gsh_fsm.sv
module gsh_fsm
  import gsh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic wr_en,
  input  logic frz,
  input  logic nrfd,
  input  logic ndac,
  input  logic tmr_done,
  output logic tmr_load,
  output logic tmr_run,
  output logic wr_acc,
  output logic acc_evt,
  output logic nolsn_evt,
  output logic dav_o
);

  hs_state_t state_q, nxt;
  logic      in_xfer;
  logic      dav_q;

  assign in_xfer   = (state_q == S_LOAD) || (state_q == S_SETTLE) ||
                     (state_q == S_WRDY) || (state_q == S_ACPT);
  assign wr_acc    = (state_q == S_IDLE) && wr_en && !frz;
  assign tmr_load  = (state_q == S_LOAD);
  assign tmr_run   = (state_q == S_SETTLE) && !frz;
  assign acc_evt   = (state_q == S_ACPT) && !ndac && !frz;
  assign nolsn_evt = (state_q == S_WRDY) && !nrfd && !ndac && !frz;

  always_comb begin
    nxt = state_q;
    if (frz && in_xfer) begin
      nxt = S_HOLD;
    end else begin
      case (state_q)
        S_IDLE:   if (wr_acc)               nxt = S_LOAD;
        S_LOAD:                             nxt = S_SETTLE;
        S_SETTLE: if (tmr_done)             nxt = S_WRDY;
        S_WRDY:   if (!nrfd && ndac)        nxt = S_ACPT;
        S_ACPT:   if (!ndac)                nxt = S_DONE;
        S_DONE:   if (ndac && !frz)         nxt = S_IDLE;
        S_HOLD:   if (!frz)                 nxt = S_LOAD;
        default:                            nxt = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      dav_q   <= 1'b0;
    end else begin
      state_q <= nxt;
      dav_q   <= (nxt == S_ACPT);
    end
  end

  assign dav_o = dav_q;

  assert_dav_ready_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(dav_o) |-> $past(!nrfd && ndac));

  assert_frz_dav_R8: assert property (@(posedge clk) disable iff (rst)
    frz |=> !dav_o);

  assert_dav_drop_R6: assert property (@(posedge clk) disable iff (rst)
    (dav_o && !ndac && !frz) |=> !dav_o);

endmodule

// File: rtl/gsh_out_regs.sv
module gsh_out_regs #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_acc,
  input  logic [DW-1:0] wr_data,
  input  logic          acc_evt,
  input  logic          nolsn_evt,
  input  logic          err_clr,
  input  logic          dma_mode,
  input  logic          frz,
  output logic [DW-1:0] data_o,
  output logic          bo_o,
  output logic          dreq_o,
  output logic          err_o
);

  logic [DW-1:0] data_q;
  logic          bo_q, dreq_q, err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      bo_q   <= 1'b0;
      dreq_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (wr_acc) data_q <= wr_data;

      if (wr_acc) begin
        bo_q   <= 1'b0;
        dreq_q <= 1'b0;
      end else if (acc_evt) begin
        bo_q   <= bo_q | !dma_mode;
        dreq_q <= dreq_q | dma_mode;
      end

      if (nolsn_evt)    err_q <= 1'b1;
      else if (err_clr) err_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign bo_o   = bo_q;
  assign dreq_o = dreq_q;
  assign err_o  = err_q;

  assert_req_excl_R6: assert property (@(posedge clk) disable iff (rst)
    !(bo_q && dreq_q));

  assert_req_on_accept_R6: assert property (@(posedge clk) disable iff (rst)
    ($rose(bo_q) || $rose(dreq_q)) |-> $past(acc_evt));

  assert_err_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    (err_q && !err_clr) |=> err_q);

  assert_frz_data_R8: assert property (@(posedge clk) disable iff (rst)
    frz |=> $stable(data_q));

endmodule

// File: rtl/gpib_src_hs.sv
module gpib_src_hs #(
  parameter int DW      = 8,
  parameter int CLK_MHZ = 200,
  parameter int T0_NS   = 350,
  parameter int T1_NS   = 500,
  parameter int T2_NS   = 1100,
  parameter int T3_NS   = 2000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    dly_sel,
  input  logic          dma_mode,
  input  logic          ctrl_active,
  input  logic          atn,
  input  logic          nrfd,
  input  logic          ndac,
  input  logic          err_clr,
  output logic [DW-1:0] dio,
  output logic          dav,
  output logic          bo_flag,
  output logic          dma_req,
  output logic          nolsn_err
);

  logic frz;
  logic tmr_load, tmr_run, tmr_done;
  logic wr_acc, acc_evt, nolsn_evt;

  assign frz = atn && !ctrl_active;

  gsh_settle_timer #(
    .CLK_MHZ(CLK_MHZ), .T0_NS(T0_NS), .T1_NS(T1_NS),
    .T2_NS(T2_NS), .T3_NS(T3_NS)
  ) u_tmr (
    .clk   (clk),
    .rst   (rst),
    .load_i(tmr_load),
    .run_i (tmr_run),
    .sel_i (dly_sel),
    .done_o(tmr_done)
  );

  gsh_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .frz      (frz),
    .nrfd     (nrfd),
    .ndac     (ndac),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .tmr_run  (tmr_run),
    .wr_acc   (wr_acc),
    .acc_evt  (acc_evt),
    .nolsn_evt(nolsn_evt),
    .dav_o    (dav)
  );

  gsh_out_regs #(.DW(DW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_acc   (wr_acc),
    .wr_data  (wr_data),
    .acc_evt  (acc_evt),
    .nolsn_evt(nolsn_evt),
    .err_clr  (err_clr),
    .dma_mode (dma_mode),
    .frz      (frz),
    .data_o   (dio),
    .bo_o     (bo_flag),
    .dreq_o   (dma_req),
    .err_o    (nolsn_err)
  );

  assert_rst_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> (!dav && !bo_flag && !dma_req && !nolsn_err));

endmodule

// File: tb/sim_gpib_src_hs.sv
`timescale 1ns/1ps
module sim_gpib_src_hs;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] dly_sel = 2'd0;
  logic       dma_mode = 1'b0;
  logic       ctrl_active = 1'b0;
  logic       atn = 1'b0;
  logic       nrfd = 1'b0;
  logic       ndac = 1'b1;
  logic       err_clr = 1'b0;
  logic [7:0] dio;
  logic       dav, bo_flag, dma_req, nolsn_err;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  gpib_src_hs u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .dly_sel(dly_sel), .dma_mode(dma_mode), .ctrl_active(ctrl_active),
    .atn(atn), .nrfd(nrfd), .ndac(ndac), .err_clr(err_clr),
    .dio(dio), .dav(dav), .bo_flag(bo_flag), .dma_req(dma_req),
    .nolsn_err(nolsn_err)
  );

  // sel, data, dma
  localparam logic [10:0] VEC [6] = '{
    {2'd0, 8'hA5, 1'b0},
    {2'd1, 8'h3C, 1'b1},
    {2'd2, 8'h00, 1'b0},
    {2'd3, 8'hFF, 1'b1},
    {2'd0, 8'h5A, 1'b1},
    {2'd1, 8'h81, 1'b0}
  };

  function automatic int exp_lat(input logic [1:0] s);
    int ns;
    case (s)
      2'd0: ns = 350;
      2'd1: ns = 500;
      2'd2: ns = 1100;
      default: ns = 2000;
    endcase
    return (ns * 200 + 999) / 1000 + 2;
  endfunction

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_data = d;
    wr_en = 1'b1;
    step();
    wr_en = 1'b0;
  endtask

  task automatic wait_dav(output int n);
    n = 0;
    while (!dav && n < 3000) begin
      step();
      n++;
    end
  endtask

  task automatic finish_hs();
    ndac = 1'b0;
    step();
    ndac = 1'b1;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) step();
    rst = 1'b0;
    step();
    chk("R1 dav", dav, 0);
    chk("R1 bo_flag", bo_flag, 0);
    chk("R1 dma_req", dma_req, 0);
    chk("R1 nolsn_err", nolsn_err, 0);

    // vector table: ready bus, each delay and both request modes
    foreach (VEC[i]) begin
      dly_sel  = VEC[i][10:9];
      dma_mode = VEC[i][0];
      do_write(VEC[i][8:1]);
      chk("R2 dio", dio, VEC[i][8:1]);
      chk("R2 flags cleared", {bo_flag, dma_req}, 0);
      wait_dav(n);
      chk("R3 latency", n, exp_lat(VEC[i][10:9]));
      ndac = 1'b0;
      step();
      chk("R6 dav fall", dav, 0);
      chk("R6 bo_flag", bo_flag, !VEC[i][0]);
      chk("R6 dma_req", dma_req, VEC[i][0]);
      ndac = 1'b1;
      step();
    end

    // R4: NRFD held, plus R2 write during settle ignored
    dly_sel = 2'd0; dma_mode = 1'b0;
    nrfd = 1'b1;
    do_write(8'h44);
    repeat (10) step();
    do_write(8'h11);
    chk("R2 busy write ignored", dio, 8'h44);
    repeat (80) step();
    chk("R4 dav waits nrfd", dav, 0);
    chk("R4 no error", nolsn_err, 0);
    nrfd = 1'b0;
    step();
    chk("R4 dav after ready", dav, 1);
    finish_hs();

    // R5: no listener
    ndac = 1'b0;
    do_write(8'h96);
    repeat (80) step();
    chk("R5 dav held low", dav, 0);
    chk("R5 err set", nolsn_err, 1);
    ndac = 1'b1;
    step();
    chk("R5 sent once listener", dav, 1);
    chk("R5 byte kept", dio, 8'h96);
    finish_hs();
    chk("R5 sticky", nolsn_err, 1);
    err_clr = 1'b1;
    step();
    err_clr = 1'b0;
    chk("R5 cleared", nolsn_err, 0);

    // R7: write before NDAC returns is ignored
    do_write(8'h2B);
    wait_dav(n);
    ndac = 1'b0;
    step();
    do_write(8'h77);
    chk("R7 write ignored", dio, 8'h2B);
    chk("R7 flag kept", bo_flag, 1);
    ndac = 1'b1;
    step();

    // R8: ATN during settle, then during DAV
    do_write(8'hC3);
    repeat (10) step();
    atn = 1'b1;
    step();
    do_write(8'h12);
    chk("R8 write ignored", dio, 8'hC3);
    repeat (100) step();
    chk("R8 frozen dav", dav, 0);
    atn = 1'b0;
    step();
    wait_dav(n);
    chk("R8 resume latency", n, exp_lat(2'd0));
    atn = 1'b1;
    step();
    chk("R8 dav dropped", dav, 0);
    chk("R8 byte held", dio, 8'hC3);
    atn = 1'b0;
    step();
    wait_dav(n);
    chk("R8 resend latency", n, exp_lat(2'd0));
    finish_hs();
    chk("R8 bo_flag", bo_flag, 1);

    // R9: controller ownership ignores ATN
    ctrl_active = 1'b1;
    atn = 1'b1;
    dly_sel = 2'd1;
    do_write(8'hE7);
    wait_dav(n);
    chk("R9 latency", n, exp_lat(2'd1));
    finish_hs();
    chk("R9 bo_flag", bo_flag, 1);
    atn = 1'b0;
    ctrl_active = 1'b0;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule